// File: doc/BRIEF.md
# Turn-Model Mesh Route Computation

This block is the route computation stage of a router in a two-dimensional mesh. It receives the router's own coordinate and a head flit's destination coordinate. From these it picks exactly one output port: East, West, North, South or Local ejection. A two-bit mode input selects one of three routing policies:

- Strict dimension order: X first, then Y.
- West-first adaptive.
- A two-plane scheme. Plane 0 runs west-first. A packet that has already turned and still needs to travel West crosses to plane 1, which runs north-last.

When a policy leaves two productive directions, per-port congestion flags decide between them. When the flags give no preference, the X direction wins.

Only head flits are routed. The result appears one clock after the head is presented. It is also written into a per-virtual-channel table, and body flits of the same packet read that table through a separate combinational lookup port.

Top module: `mesh_route_unit`

## Requirements
- R1: When the destination equals the router's own coordinate, the Local port (bit 4) is chosen, whatever the mode.
- R2: `rt_valid` is high exactly one cycle after `hd_valid` was high. While valid, `rt_port` is one-hot with bit 0 = East (+x), bit 1 = West (-x), bit 2 = North (+y), bit 3 = South (-y), bit 4 = Local. When not valid, `rt_port`, `rt_plane` and `rt_vc` are zero. When valid, `rt_vc` echoes `hd_vc`.
- R3: Mode codes 0 and 3 route in dimension order: East or West until X matches, then North or South. Congestion flags have no effect, and the plane bit is 0.
- R4: Mode 1 (west-first) sends a packet whose destination lies west straight to West, regardless of congestion. The plane bit is 0.
- R5: In mode 1 with no westward need, if both East and a Y direction are productive, the one whose congestion flag is clear is taken. If both flags are equal, East is taken. A single productive direction is taken directly.
- R6: In mode 2, a plane-0 packet may go West only if it entered on the East input (`hd_in_port` = 0) or the Local input (4). Such packets, and plane-0 packets with no westward need, follow R4/R5 and leave with plane bit 0.
- R7: In mode 2, a plane-0 packet that needs West but entered on the West, North or South input (`hd_in_port` = 1, 2, 3) is moved to plane 1 (`rt_plane` = 1) and routed north-last.
- R8: North-last routing (plane-1 packets in mode 2): North is chosen only when X already matches and no South move is needed. Otherwise the choice is between the X direction and South by congestion, with ties going to X. The plane bit stays 1.
- R9: Each head writes its port and plane into the entry of its VC on the same edge that raises `rt_valid`. `bd_port`/`bd_plane` show the entry selected by `bd_vc`. Reset clears all entries to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | Policy: 0/3 dimension order, 1 west-first, 2 two-plane |
| my_x | input | CW | Router X coordinate |
| my_y | input | CW | Router Y coordinate |
| hd_valid | input | 1 | Head flit present |
| hd_vc | input | VCW | Virtual channel of the head |
| hd_dst_x | input | CW | Destination X |
| hd_dst_y | input | CW | Destination Y |
| hd_plane | input | 1 | Current plane of the packet |
| hd_in_port | input | 3 | Input port the head arrived on (0 E,1 W,2 N,3 S,4 L) |
| cong | input | 5 | Per-output congestion flags, same bit order as rt_port |
| bd_vc | input | VCW | VC selector for body-flit lookup |
| rt_valid | output | 1 | Route result valid |
| rt_port | output | 5 | One-hot output port |
| rt_plane | output | 1 | Plane the packet leaves on |
| rt_vc | output | VCW | VC of the routed head |
| bd_port | output | 5 | Stored port for `bd_vc` |
| bd_plane | output | 1 | Stored plane for `bd_vc` |

## Verification
The bench aims at the places where a policy stops being productive-only. Examples:
- A westward destination under congestion in west-first mode. A design that treated West as adaptive would turn North or East and break the turn rule.
- A plane-0 packet that needs West and arrives from North or South. A design that missed the crossover would leave on plane 0 or head North too early.
- Ties with both flags set, which must fall to X. A design that preferred Y would show up as a South or North result.
- Lookups of one VC while a different VC is written. A table that wrote every entry, or wrote one cycle late, returns a stale or wrong port.

// File: rtl/mroute_pkg.sv
package mroute_pkg;

  localparam int NPORT = 5;
  localparam int P_E = 0;
  localparam int P_W = 1;
  localparam int P_N = 2;
  localparam int P_S = 3;
  localparam int P_L = 4;

  typedef logic [NPORT-1:0] pvec_t;

  typedef enum logic [1:0] {
    M_XY    = 2'd0,
    M_WF    = 2'd1,
    M_PLANE = 2'd2,
    M_XY2   = 2'd3
  } rmode_e;

  typedef struct packed {
    logic e;
    logic w;
    logic n;
    logic s;
    logic here;
  } need_t;

  function automatic pvec_t port_bit(input int idx);
    pvec_t v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  // choose between an X candidate and a Y candidate using congestion
  function automatic pvec_t pick_pair(input logic hx, input int xi,
                                      input logic hy, input int yi,
                                      input pvec_t cg);
    if (hx && hy) begin
      if (cg[xi] && !cg[yi]) return port_bit(yi);
      return port_bit(xi);
    end
    if (hx) return port_bit(xi);
    if (hy) return port_bit(yi);
    return '0;
  endfunction

  function automatic pvec_t route_xy(input need_t nd);
    if (nd.here) return port_bit(P_L);
    if (nd.e)    return port_bit(P_E);
    if (nd.w)    return port_bit(P_W);
    if (nd.n)    return port_bit(P_N);
    if (nd.s)    return port_bit(P_S);
    return '0;
  endfunction

  function automatic pvec_t route_wf(input need_t nd, input pvec_t cg);
    if (nd.here) return port_bit(P_L);
    if (nd.w)    return port_bit(P_W);
    return pick_pair(nd.e, P_E, nd.n | nd.s, nd.n ? P_N : P_S, cg);
  endfunction

  function automatic pvec_t route_nl(input need_t nd, input pvec_t cg);
    if (nd.here) return port_bit(P_L);
    if (nd.e || nd.w || nd.s)
      return pick_pair(nd.e | nd.w, nd.e ? P_E : P_W, nd.s, P_S, cg);
    if (nd.n) return port_bit(P_N);
    return '0;
  endfunction

endpackage

// File: rtl/mroute_offset.sv
module mroute_offset
  import mroute_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic [CW-1:0] cur_x,
  input  logic [CW-1:0] cur_y,
  input  logic [CW-1:0] dst_x,
  input  logic [CW-1:0] dst_y,
  output need_t         need
);

  always_comb begin
    need.e    = dst_x > cur_x;
    need.w    = dst_x < cur_x;
    need.n    = dst_y > cur_y;
    need.s    = dst_y < cur_y;
    need.here = (dst_x == cur_x) && (dst_y == cur_y);
  end

endmodule

// File: rtl/mroute_select.sv
module mroute_select
  import mroute_pkg::*;
(
  input  logic [1:0] mode_i,
  input  need_t      need,
  input  pvec_t      cong_i,
  input  logic [2:0] in_port,
  input  logic       in_plane,
  output pvec_t      port_o,
  output logic       plane_o,
  output logic       cross_o
);

  logic west_ok;

  assign west_ok = (in_port == 3'(P_E)) || (in_port == 3'(P_L));

  always_comb begin
    port_o  = '0;
    plane_o = 1'b0;
    cross_o = 1'b0;
    case (mode_i)
      M_WF: port_o = route_wf(need, cong_i);
      M_PLANE: begin
        if (in_plane) begin
          port_o  = route_nl(need, cong_i);
          plane_o = 1'b1;
        end else if (need.w && !west_ok) begin
          port_o  = route_nl(need, cong_i);
          plane_o = 1'b1;
          cross_o = 1'b1;
        end else begin
          port_o = route_wf(need, cong_i);
        end
      end
      default: port_o = route_xy(need);
    endcase
  end

endmodule

// File: rtl/mroute_vc_table.sv
module mroute_vc_table
  import mroute_pkg::*;
#(
  parameter int NVC = 4,
  localparam int VCW = (NVC > 1) ? $clog2(NVC) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [VCW-1:0] wr_vc,
  input  pvec_t          wr_port,
  input  logic           wr_plane,
  input  logic [VCW-1:0] rd_vc,
  output pvec_t          rd_port,
  output logic           rd_plane
);

  pvec_t      ent_port  [NVC];
  logic [NVC-1:0] ent_plane;

  for (genvar v = 0; v < NVC; v++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_port[v]  <= '0;
        ent_plane[v] <= 1'b0;
      end else if (wr_en && (wr_vc == VCW'(v))) begin
        ent_port[v]  <= wr_port;
        ent_plane[v] <= wr_plane;
      end
    end
  end

  always_comb begin
    rd_port  = '0;
    rd_plane = 1'b0;
    if (int'(rd_vc) < NVC) begin
      rd_port  = ent_port[rd_vc];
      rd_plane = ent_plane[rd_vc];
    end
  end

endmodule

// File: rtl/mesh_route_unit.sv
module mesh_route_unit
  import mroute_pkg::*;
#(
  parameter int CW  = 4,
  parameter int NVC = 4,
  localparam int VCW = (NVC > 1) ? $clog2(NVC) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     cfg_mode,
  input  logic [CW-1:0]  my_x,
  input  logic [CW-1:0]  my_y,
  input  logic           hd_valid,
  input  logic [VCW-1:0] hd_vc,
  input  logic [CW-1:0]  hd_dst_x,
  input  logic [CW-1:0]  hd_dst_y,
  input  logic           hd_plane,
  input  logic [2:0]     hd_in_port,
  input  logic [4:0]     cong,
  input  logic [VCW-1:0] bd_vc,
  output logic           rt_valid,
  output logic [4:0]     rt_port,
  output logic           rt_plane,
  output logic [VCW-1:0] rt_vc,
  output logic [4:0]     bd_port,
  output logic           bd_plane
);

  need_t need_w;
  pvec_t route_vec;
  logic  route_plane;
  logic  cross_evt;
  logic  head_fire;

  assign head_fire = hd_valid;

  mroute_offset #(.CW(CW)) u_offset (
    .cur_x (my_x),
    .cur_y (my_y),
    .dst_x (hd_dst_x),
    .dst_y (hd_dst_y),
    .need  (need_w)
  );

  mroute_select u_select (
    .mode_i   (cfg_mode),
    .need     (need_w),
    .cong_i   (cong),
    .in_port  (hd_in_port),
    .in_plane (hd_plane),
    .port_o   (route_vec),
    .plane_o  (route_plane),
    .cross_o  (cross_evt)
  );

  mroute_vc_table #(.NVC(NVC)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (head_fire),
    .wr_vc    (hd_vc),
    .wr_port  (route_vec),
    .wr_plane (route_plane),
    .rd_vc    (bd_vc),
    .rd_port  (bd_port),
    .rd_plane (bd_plane)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rt_valid <= 1'b0;
      rt_port  <= '0;
      rt_plane <= 1'b0;
      rt_vc    <= '0;
    end else begin
      rt_valid <= head_fire;
      rt_port  <= head_fire ? route_vec : '0;
      rt_plane <= head_fire & route_plane;
      rt_vc    <= head_fire ? hd_vc : '0;
    end
  end

endmodule

// File: rtl/mroute_checker.sv
module mroute_checker #(
  parameter int CW  = 4,
  parameter int VCW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic [1:0]     cfg_mode,
  input logic [CW-1:0]  my_x,
  input logic [CW-1:0]  my_y,
  input logic           hd_valid,
  input logic [CW-1:0]  hd_dst_x,
  input logic [CW-1:0]  hd_dst_y,
  input logic           hd_plane,
  input logic           cross_evt,
  input logic [VCW-1:0] bd_vc,
  input logic           rt_valid,
  input logic [4:0]     rt_port,
  input logic           rt_plane,
  input logic [VCW-1:0] rt_vc,
  input logic [4:0]     bd_port
);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    hd_valid |=> rt_valid);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !hd_valid |=> (!rt_valid && rt_port == 5'd0 && !rt_plane));

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    rt_valid |-> $onehot(rt_port));

  a_r1_local: assert property (@(posedge clk) disable iff (!rst_n)
    (hd_valid && hd_dst_x == my_x && hd_dst_y == my_y) |=> rt_port[4]);

  a_r3_x_first: assert property (@(posedge clk) disable iff (!rst_n)
    (hd_valid && (cfg_mode == 2'd0 || cfg_mode == 2'd3) && hd_dst_x != my_x)
      |=> (!rt_port[2] && !rt_port[3]));

  a_r4_west_first: assert property (@(posedge clk) disable iff (!rst_n)
    (hd_valid && cfg_mode == 2'd1 && hd_dst_x < my_x) |=> (rt_port == 5'b00010));

  a_r7_cross_plane: assert property (@(posedge clk) disable iff (!rst_n)
    (hd_valid && cross_evt) |=> rt_plane);

  a_r8_north_last: assert property (@(posedge clk) disable iff (!rst_n)
    (hd_valid && cfg_mode == 2'd2 && hd_plane && (hd_dst_x != my_x || hd_dst_y < my_y))
      |=> !rt_port[2]);

  a_r9_table_match: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_valid && bd_vc == rt_vc) |-> (bd_port == rt_port));

endmodule

bind mesh_route_unit mroute_checker #(.CW(CW), .VCW(VCW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_mode  (cfg_mode),
  .my_x      (my_x),
  .my_y      (my_y),
  .hd_valid  (hd_valid),
  .hd_dst_x  (hd_dst_x),
  .hd_dst_y  (hd_dst_y),
  .hd_plane  (hd_plane),
  .cross_evt (cross_evt),
  .bd_vc     (bd_vc),
  .rt_valid  (rt_valid),
  .rt_port   (rt_port),
  .rt_plane  (rt_plane),
  .rt_vc     (rt_vc),
  .bd_port   (bd_port)
);

// File: tb/mesh_route_unit_tb.sv
`timescale 1ns/1ps
module mesh_route_unit_tb;

  localparam int CW  = 4;
  localparam int NVC = 4;
  localparam int VCW = 2;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [1:0]     cfg_mode;
  logic [CW-1:0]  my_x, my_y, hd_dst_x, hd_dst_y;
  logic           hd_valid, hd_plane;
  logic [VCW-1:0] hd_vc, bd_vc;
  logic [2:0]     hd_in_port;
  logic [4:0]     cong;
  logic           rt_valid, rt_plane, bd_plane;
  logic [4:0]     rt_port, bd_port;
  logic [VCW-1:0] rt_vc;

  int n_vec = 0;
  int n_bad = 0;
  int mdl_port  [NVC];
  int mdl_plane [NVC];

  always #5 clk = ~clk;

  mesh_route_unit #(.CW(CW), .NVC(NVC)) u_dut (.*);

  // behavioural reference: returns port index (0..4), plane and the rule tag
  task automatic ref_route(input int mode, input int mx, input int my,
                           input int dx, input int dy, input int pl,
                           input int inp, input logic [4:0] cg,
                           output int port, output int opl, output string tag);
    int ox, oy, xd, yd;
    bit use_nl;
    ox = dx - mx;
    oy = dy - my;
    xd = (ox > 0) ? 0 : 1;
    yd = (oy > 0) ? 2 : 3;
    opl = 0;
    use_nl = 0;
    if (mode == 2) begin
      if (pl == 1) begin use_nl = 1; opl = 1; tag = "R8"; end
      else if (ox < 0 && inp != 0 && inp != 4) begin use_nl = 1; opl = 1; tag = "R7"; end
      else tag = "R6";
    end else if (mode == 1) tag = (ox < 0) ? "R4" : "R5";
    else tag = "R3";
    if (ox == 0 && oy == 0) begin
      port = 4;
      tag = "R1";
    end else if (mode == 0 || mode == 3) begin
      port = (ox != 0) ? xd : yd;
    end else if (use_nl) begin
      if (ox != 0 && oy < 0) port = (cg[xd] && !cg[3]) ? 3 : xd;
      else if (ox != 0) port = xd;
      else if (oy < 0) port = 3;
      else port = 2;
    end else begin
      if (ox < 0) port = 1;
      else if (ox > 0 && oy != 0) port = (cg[0] && !cg[yd]) ? yd : 0;
      else if (ox > 0) port = 0;
      else port = yd;
    end
  endtask

  task automatic apply(input bit hv, input int mode, input int mx, input int my,
                       input int dx, input int dy, input int pl, input int inp,
                       input logic [4:0] cg, input int vc, input int bvc);
    int ep, epl;
    string tag;
    logic [4:0] exp_port;
    logic exp_plane;
    cfg_mode = 2'(mode); my_x = CW'(mx); my_y = CW'(my);
    hd_dst_x = CW'(dx); hd_dst_y = CW'(dy); hd_plane = pl[0];
    hd_in_port = 3'(inp); cong = cg; hd_vc = VCW'(vc); bd_vc = VCW'(bvc);
    hd_valid = hv;
    ref_route(mode, mx, my, dx, dy, pl, inp, cg, ep, epl, tag);
    if (hv) begin
      exp_port = 5'(1 << ep);
      exp_plane = epl[0];
      mdl_port[vc] = 1 << ep;
      mdl_plane[vc] = epl;
    end else begin
      exp_port = '0;
      exp_plane = 1'b0;
      tag = "R2";
    end
    @(negedge clk);
    n_vec++;
    if (rt_valid !== hv || rt_port !== exp_port || rt_plane !== exp_plane ||
        rt_vc !== (hv ? VCW'(vc) : VCW'(0))) begin
      n_bad++;
      $display("FAIL %s/R2 route: valid=%0b port=%b plane=%0b vc=%0d expected valid=%0b port=%b plane=%0b vc=%0d",
               tag, rt_valid, rt_port, rt_plane, rt_vc, hv, exp_port, exp_plane, hv ? vc : 0);
    end
    n_vec++;
    if (bd_port !== 5'(mdl_port[bvc]) || bd_plane !== mdl_plane[bvc][0]) begin
      n_bad++;
      $display("FAIL R9 lookup vc%0d: port=%b plane=%0b expected port=%b plane=%0b",
               bvc, bd_port, bd_plane, 5'(mdl_port[bvc]), mdl_plane[bvc][0]);
    end
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NVC; i++) begin mdl_port[i] = 0; mdl_plane[i] = 0; end
    rst_n = 1'b0;
    hd_valid = 0; cfg_mode = 0; my_x = 0; my_y = 0; hd_dst_x = 0; hd_dst_y = 0;
    hd_plane = 0; hd_in_port = 4; cong = 0; hd_vc = 0; bd_vc = 0;
    repeat (3) @(negedge clk);
    // reset state, R2 and R9
    n_vec++;
    if (rt_valid !== 0 || rt_port !== 0 || rt_plane !== 0 || bd_port !== 0 || bd_plane !== 0) begin
      n_bad++;
      $display("FAIL R2 reset: valid=%0b port=%b bd=%b expected all zero", rt_valid, rt_port, bd_port);
    end
    rst_n = 1'b1;
    // R1 local in each mode
    apply(1, 0, 5, 5, 5, 5, 0, 4, 5'b11111, 0, 0);
    apply(1, 2, 3, 7, 3, 7, 1, 2, 5'b00000, 1, 1);
    // R3 X first, congestion ignored
    apply(1, 0, 2, 2, 6, 0, 0, 4, 5'b00001, 2, 2);
    apply(1, 3, 6, 2, 6, 9, 0, 4, 5'b00100, 3, 3);
    // R4 west first under congestion on West
    apply(1, 1, 8, 4, 2, 9, 0, 2, 5'b00010, 0, 0);
    // R5 tie goes to East, congested East yields North
    apply(1, 1, 2, 2, 5, 6, 0, 4, 5'b00101, 1, 1);
    apply(1, 1, 2, 2, 5, 6, 0, 4, 5'b00001, 1, 1);
    apply(1, 1, 2, 9, 5, 1, 0, 4, 5'b00001, 2, 1);
    // R6 plane 0 westward from East/Local stays on plane 0
    apply(1, 2, 9, 3, 1, 8, 0, 0, 5'b00000, 3, 3);
    apply(1, 2, 9, 3, 1, 8, 0, 4, 5'b00010, 3, 0);
    // R7 crossover from North/South/West inputs
    apply(1, 2, 9, 8, 1, 3, 0, 2, 5'b00000, 0, 3);
    apply(1, 2, 9, 8, 1, 3, 0, 3, 5'b00010, 1, 0);
    // R8 north-last: north only when alone
    apply(1, 2, 4, 4, 4, 12, 1, 2, 5'b00000, 2, 2);
    apply(1, 2, 4, 4, 9, 12, 1, 2, 5'b00000, 2, 2);
    apply(1, 2, 4, 8, 1, 2, 1, 0, 5'b00010, 2, 2);
    // idle cycles: R2
    apply(0, 1, 0, 0, 3, 3, 0, 4, 5'b00000, 0, 1);
    apply(0, 2, 0, 0, 0, 0, 0, 4, 5'b11111, 0, 3);
    // randomized sweep
    for (int k = 0; k < 600; k++) begin
      apply(($urandom % 4) != 0, $urandom % 4, $urandom % 16, $urandom % 16,
            $urandom % 16, $urandom % 16, $urandom % 2, $urandom % 5,
            5'($urandom), $urandom % NVC, $urandom % NVC);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule